// File: doc/BRIEF.md
# Program-Space Data Window Bridge

This block lets data-side loads read constants that are stored in a 24-bit-wide program memory. Part of a 16-bit data address space can be pointed at program memory. A read whose effective address has its top bit set becomes a paged program-memory fetch, but only when the window is switched on and no explicit table transfer is running. The program address is built from an 8-bit page value and the low 15 bits of the data address. Only the low 16 bits of the fetched word come back as load data. The page value and the enable bit sit in a small configuration register that a write strobe loads.

Each windowed read holds the pipeline with a stall output for the number of extra cycles the access costs. Outside a hardware repeat loop, the cost depends on the instruction class. Inside a loop, the cost depends on where the iteration sits: at a boundary or an interrupt transition it costs two extra cycles, and in the steady state it costs none. Reads that are not windowed are handed to ordinary data RAM through a separate strobe.

Top module: `pgm_window_bridge`

## Requirements
- R1: An accepted read (readReq high while stall is low) is windowed when dataAddr[15] is 1, the window is enabled and tableBusy is 0. Such a read raises pmRead in the same cycle with ramRead low.
- R2: An accepted read that is not windowed raises ramRead in the same cycle. It gives no pmRead, no stall and no dataValid.
- R3: During pmRead, pmAddr equals {page, dataAddr[14:0]}, with the page in bits [22:15].
- R4: The program memory returns a word in the cycle after pmRead. dataOut carries bits [15:0] of that word when dataValid is high, and bits [23:16] never reach dataOut.
- R5: Outside a repeat loop (inRepeat=0) with fastClass=1, stall is high for exactly one cycle after pmRead, and dataValid is high in the cycle after that.
- R6: Outside a repeat loop with fastClass=0, stall is high for exactly two cycles, and dataValid follows them.
- R7: Inside a repeat loop, any of rptFirst, rptLast, rptIntExit or rptReentry gives exactly two stall cycles.
- R8: Inside a repeat loop with none of those four flags set, there is no stall and dataValid is high in the cycle right after pmRead.
- R9: While tableBusy is 1, no read is redirected to program memory.
- R10: After reset the window is disabled and the page is 0, so a read at 0x8000 goes to RAM.
- R11: A configuration write (cfgWe) applies to reads accepted after the clock edge that registers it. A read in the same cycle as the write uses the old setting.
- R12: A readReq arriving while stall is high is ignored: neither pmRead nor ramRead is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Loads the window enable and page values |
| cfgWinEn | input | 1 | Window enable value to load |
| cfgPage | input | 8 | Page value to load |
| readReq | input | 1 | Data read request |
| dataAddr | input | 16 | Data effective address |
| tableBusy | input | 1 | Explicit table transfer in progress |
| fastClass | input | 1 | Instruction is a MAC operand read or a word/double move |
| inRepeat | input | 1 | Access is inside a hardware repeat loop |
| rptFirst | input | 1 | First loop iteration |
| rptLast | input | 1 | Last loop iteration |
| rptIntExit | input | 1 | Leaving the loop for an interrupt |
| rptReentry | input | 1 | Re-entering the loop after an interrupt |
| pmData | input | 24 | Program memory word, valid the cycle after pmRead |
| pmRead | output | 1 | Program memory read strobe |
| pmAddr | output | 23 | Program memory address |
| ramRead | output | 1 | Data RAM read strobe |
| stall | output | 1 | Adds a wait cycle |
| dataValid | output | 1 | dataOut holds the windowed result |
| dataOut | output | 16 | Low 16 bits of the fetched word |

## Verification
The checker watches these on every cycle: the program and RAM strobes never fire together, table transfers block redirection, requests are dropped while stalled, the address offset passes straight through, and the one-cycle and zero-cycle stall profiles hold. The bench scenarios cover the rest. They compute the exact stall length for each class and each loop position, check the returned low half-word against a memory model, check that configuration writes take effect one cycle later, and check the state after reset.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int STALL_W = 2;

  typedef struct packed {
    logic capture;
    logic useHold;
  } pwbStrobes_t;

  function automatic logic [STALL_W-1:0] extraCycles(
    input logic fastClass, input logic inRepeat,
    input logic rptFirst, input logic rptLast,
    input logic rptIntExit, input logic rptReentry);
    logic edgeIter;
    edgeIter = rptFirst | rptLast | rptIntExit | rptReentry;
    if (inRepeat) extraCycles = edgeIter ? STALL_W'(2) : STALL_W'(0);
    else          extraCycles = fastClass ? STALL_W'(1) : STALL_W'(2);
  endfunction
endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 8,
  parameter int PM_W   = 24,
  localparam int OFS_W = DATA_W - 1,
  localparam int PMA_W = PAGE_W + OFS_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgWinEn,
  input  logic [PAGE_W-1:0] cfgPage,
  input  logic [OFS_W-1:0]  addrOfs,
  input  logic [PM_W-1:0]   pmData,
  input  pwbStrobes_t       strobes,
  output logic              winEnQ,
  output logic [PMA_W-1:0]  pmAddr,
  output logic [DATA_W-1:0] dataOut
);
  logic [PAGE_W-1:0] pageQ;
  logic [DATA_W-1:0] holdQ;
  logic [DATA_W-1:0] lowHalf;
  logic              unusedUpper;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winEnQ <= 1'b0;
      pageQ  <= '0;
    end else if (cfgWe) begin
      winEnQ <= cfgWinEn;
      pageQ  <= cfgPage;
    end
  end

  assign pmAddr      = {pageQ, addrOfs};
  assign lowHalf     = pmData[DATA_W-1:0];
  assign unusedUpper = ^pmData[PM_W-1:DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN)                holdQ <= '0;
    else if (strobes.capture) holdQ <= lowHalf;
  end

  assign dataOut = strobes.useHold ? holdQ : lowHalf;
endmodule

// File: rtl/pwb_control.sv
module pwb_control
  import pwb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        readReq,
  input  logic        addrMsb,
  input  logic        winEnQ,
  input  logic        tableBusy,
  input  logic        fastClass,
  input  logic        inRepeat,
  input  logic        rptFirst,
  input  logic        rptLast,
  input  logic        rptIntExit,
  input  logic        rptReentry,
  output logic        pmRead,
  output logic        ramRead,
  output logic        stall,
  output logic        dataValid,
  output pwbStrobes_t strobes
);
  logic [STALL_W-1:0] stallCntQ;
  logic               capPendQ;
  logic               validQ;
  logic               accept;
  logic               windowed;

  assign stall    = (stallCntQ != '0);
  assign accept   = readReq & ~stall;
  assign windowed = addrMsb & winEnQ & ~tableBusy;
  assign pmRead   = accept & windowed;
  assign ramRead  = accept & ~windowed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCntQ <= '0;
      capPendQ  <= 1'b0;
      validQ    <= 1'b0;
    end else begin
      capPendQ <= pmRead;
      validQ   <= stall && (stallCntQ == STALL_W'(1));
      if (pmRead)
        stallCntQ <= extraCycles(fastClass, inRepeat, rptFirst, rptLast,
                                 rptIntExit, rptReentry);
      else if (stall)
        stallCntQ <= stallCntQ - STALL_W'(1);
    end
  end

  assign dataValid       = (capPendQ && !stall) || validQ;
  assign strobes.capture = capPendQ;
  assign strobes.useHold = validQ;
endmodule

// File: rtl/pgm_window_bridge.sv
module pgm_window_bridge
  import pwb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 8,
  parameter int PM_W   = 24,
  localparam int OFS_W = DATA_W - 1,
  localparam int PMA_W = PAGE_W + OFS_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgWinEn,
  input  logic [PAGE_W-1:0] cfgPage,
  input  logic              readReq,
  input  logic [DATA_W-1:0] dataAddr,
  input  logic              tableBusy,
  input  logic              fastClass,
  input  logic              inRepeat,
  input  logic              rptFirst,
  input  logic              rptLast,
  input  logic              rptIntExit,
  input  logic              rptReentry,
  input  logic [PM_W-1:0]   pmData,
  output logic              pmRead,
  output logic [PMA_W-1:0]  pmAddr,
  output logic              ramRead,
  output logic              stall,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataOut
);
  pwbStrobes_t strobes;
  logic        winEnQ;

  pwb_control u_ctrl (
    .clk(clk), .rstN(rstN), .readReq(readReq),
    .addrMsb(dataAddr[DATA_W-1]), .winEnQ(winEnQ), .tableBusy(tableBusy),
    .fastClass(fastClass), .inRepeat(inRepeat), .rptFirst(rptFirst),
    .rptLast(rptLast), .rptIntExit(rptIntExit), .rptReentry(rptReentry),
    .pmRead(pmRead), .ramRead(ramRead), .stall(stall),
    .dataValid(dataValid), .strobes(strobes)
  );

  pwb_datapath #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .PM_W(PM_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWinEn(cfgWinEn),
    .cfgPage(cfgPage), .addrOfs(dataAddr[OFS_W-1:0]), .pmData(pmData),
    .strobes(strobes), .winEnQ(winEnQ), .pmAddr(pmAddr), .dataOut(dataOut)
  );
endmodule

// File: rtl/pgm_window_bridge_chk.sv
module pgm_window_bridge_chk #(
  parameter int DATA_W = 16,
  parameter int PMA_W  = 23
)(
  input logic              clk,
  input logic              rstN,
  input logic              readReq,
  input logic [DATA_W-1:0] dataAddr,
  input logic              tableBusy,
  input logic              fastClass,
  input logic              inRepeat,
  input logic              rptFirst,
  input logic              rptLast,
  input logic              rptIntExit,
  input logic              rptReentry,
  input logic              pmRead,
  input logic [PMA_W-1:0]  pmAddr,
  input logic              ramRead,
  input logic              stall,
  input logic              dataValid
);
  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pmRead && ramRead));
  // R1
  request_served_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && !stall) |-> (pmRead || ramRead));
  // R9
  table_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    tableBusy |-> !pmRead);
  // R12
  stall_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!pmRead && !ramRead));
  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmRead |-> (pmAddr[DATA_W-2:0] == dataAddr[DATA_W-2:0]));
  // R5
  fast_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pmRead && !inRepeat && fastClass) |=> (stall ##1 (!stall && dataValid)));
  // R8
  loop_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pmRead && inRepeat && !(rptFirst || rptLast || rptIntExit || rptReentry))
      |=> (!stall && dataValid));
  // R4
  valid_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !stall);
endmodule

bind pgm_window_bridge pgm_window_bridge_chk #(.DATA_W(DATA_W), .PMA_W(PMA_W)) u_chk (
  .clk(clk), .rstN(rstN), .readReq(readReq), .dataAddr(dataAddr),
  .tableBusy(tableBusy), .fastClass(fastClass), .inRepeat(inRepeat),
  .rptFirst(rptFirst), .rptLast(rptLast), .rptIntExit(rptIntExit),
  .rptReentry(rptReentry), .pmRead(pmRead), .pmAddr(pmAddr),
  .ramRead(ramRead), .stall(stall), .dataValid(dataValid)
);

// File: tb/pgm_window_bridge_bench.sv
module pgm_window_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgWinEn = 1'b0;
  logic [7:0]  cfgPage = '0;
  logic        readReq = 1'b0;
  logic [15:0] dataAddr = '0;
  logic        tableBusy = 1'b0, fastClass = 1'b0, inRepeat = 1'b0;
  logic        rptFirst = 1'b0, rptLast = 1'b0, rptIntExit = 1'b0, rptReentry = 1'b0;
  logic [23:0] pmData = '0;
  logic        pmRead, ramRead, stall, dataValid;
  logic [22:0] pmAddr;
  logic [15:0] dataOut;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pgm_window_bridge u_pgm_window_bridge (.*);

  function automatic logic [23:0] memWord(input logic [22:0] a);
    return {a[7:0] ^ 8'hC3, a[15:0] ^ 16'h5A3C};
  endfunction

  always_ff @(posedge clk) if (pmRead) pmData <= memWord(pmAddr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic en, input logic [7:0] pg);
    @(negedge clk);
    cfgWe = 1'b1; cfgWinEn = en; cfgPage = pg;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // addr, en, page, tbl, fast, rep, flags{reentry,exit,last,first}, expWin, expN
  localparam int NV = 11;
  localparam logic [34:0] VECS [NV] = '{
    {16'h8123, 1'b1, 8'h05, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1, 2'd1},
    {16'h8124, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 2'd2},
    {16'hFFFE, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, 4'b0001, 1'b1, 2'd2},
    {16'h8000, 1'b1, 8'h10, 1'b0, 1'b1, 1'b1, 4'b0010, 1'b1, 2'd2},
    {16'h9000, 1'b1, 8'h33, 1'b0, 1'b0, 1'b1, 4'b0100, 1'b1, 2'd2},
    {16'hA002, 1'b1, 8'h44, 1'b0, 1'b1, 1'b1, 4'b1000, 1'b1, 2'd2},
    {16'hC00A, 1'b1, 8'h01, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1, 2'd0},
    {16'h7FFE, 1'b1, 8'h05, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 2'd0},
    {16'h8123, 1'b0, 8'h05, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 2'd0},
    {16'h8123, 1'b1, 8'h05, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b0, 2'd0},
    {16'h0000, 1'b1, 8'h22, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, 2'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state, window off
    @(negedge clk);
    chk("R10 stall after reset", stall, 0);
    chk("R10 dataValid after reset", dataValid, 0);
    readReq = 1'b1; dataAddr = 16'h8000;
    #1;
    chk("R10 ramRead at 0x8000", ramRead, 1);
    chk("R10 pmRead at 0x8000", pmRead, 0);
    @(negedge clk); readReq = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      logic [22:0] expAddr;
      int n;
      v = VECS[i];
      n = int'(v[1:0]);
      writeCfg(v[18], v[17:10]);
      @(negedge clk);
      dataAddr = v[34:19]; tableBusy = v[9]; fastClass = v[8]; inRepeat = v[7];
      {rptReentry, rptIntExit, rptLast, rptFirst} = v[6:3];
      readReq = 1'b1;
      #1;
      expAddr = {v[17:10], v[33:19]};
      if (v[2]) begin
        chk("R1 pmRead windowed", pmRead, 1);
        chk("R1 ramRead windowed", ramRead, 0);
        chk("R3 pmAddr", pmAddr, expAddr);
      end else begin
        chk(v[9] ? "R9 pmRead blocked" : "R2 pmRead off", pmRead, 0);
        chk("R2 ramRead", ramRead, 1);
      end
      @(negedge clk);
      readReq = 1'b0;
      if (v[2]) begin
        for (int c = 1; c <= n + 1; c++) begin
          if (c > 1) @(negedge clk);
          chk(inRepeat ? "R7/R8 stall profile" : (fastClass ? "R5 stall profile" : "R6 stall profile"),
              stall, (c <= n) ? 1 : 0);
          chk("R4 dataValid timing", dataValid, (c == n + 1) ? 1 : 0);
          if (c == n + 1) chk("R4 dataOut low half", dataOut, memWord(expAddr) & 24'h00FFFF);
        end
      end else begin
        chk("R2 no stall", stall, 0);
        chk("R2 no dataValid", dataValid, 0);
      end
      {tableBusy, inRepeat, rptReentry, rptIntExit, rptLast, rptFirst} = '0;
      @(negedge clk);
    end

    // R11: write and request in the same cycle uses old setting
    writeCfg(1'b0, 8'h00);
    @(negedge clk);
    cfgWe = 1'b1; cfgWinEn = 1'b1; cfgPage = 8'h5C;
    readReq = 1'b1; dataAddr = 16'h8456; fastClass = 1'b1;
    #1;
    chk("R11 same-cycle write uses old", ramRead, 1);
    @(negedge clk);
    cfgWe = 1'b0;
    #1;
    chk("R11 next request windowed", pmRead, 1);
    chk("R11 new page used", pmAddr, {8'h5C, 15'h0456});
    fastClass = 1'b0;
    @(negedge clk);
    // R12: request during stall ignored
    #1;
    chk("R12 stall active", stall, 1);
    chk("R12 no pmRead in stall", pmRead, 0);
    chk("R12 no ramRead in stall", ramRead, 0);
    @(negedge clk); readReq = 1'b0;
    @(negedge clk);
    chk("R12 dataValid after two stalls", dataValid, 1);
    chk("R4 dataOut after ignored request", dataOut, memWord({8'h5C, 15'h0456}) & 24'h00FFFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule